// File: doc/BRIEF.md
# Transport Stream PID Filter Bank

This block sits on a byte-wide MPEG transport stream and passes only the packets whose 13-bit packet identifier is wanted. A start strobe marks the first byte of each 188-byte packet. The block keeps the first three bytes in a small holding register. When the third byte arrives, it builds the identifier from the low five bits of byte 1 and all eight bits of byte 2. It compares this value in parallel against a bank of programmable slots. The block makes its pass or drop decision in that same cycle and holds it for the rest of the packet.

An accepted packet leaves the block whole, starting with its 0x47 sync byte, on a byte stream with valid and start strobes. The same bytes are also packed into 32-bit words, in one of two byte orders. A packet that fails the sync check is discarded and counted. A word-addressed register port sets up the slots. Slot 0 also carries three controls that act on the whole filter: pass everything, block all filtered traffic, and output word byte order.

Top module: `tsf_pid_filter`

## Requirements
- R1: Slots sit at byte addresses 4*n for n = 0..NUM_SLOTS-1. Each slot stores a PID in bits 12:0 and an enable in bit 15. Slot 0 also stores a pass-all control in bit 16, a word byte order control in bit 14 and a block control in bit 13. All other bits read as 0. An address with bits 1:0 not zero, or one at 4*NUM_SLOTS or above, reads 0 and ignores writes.
- R2: After reset, every slot reads 0x00001FFF (enable clear, PID all ones), the output strobes are low and the sync-error count is 0.
- R3: A packet with a good sync byte is forwarded when an enabled slot's PID equals {byte1[4:0], byte2}. A slot whose enable is clear never causes a match. With no match, and with pass-all and block both clear, the packet is dropped.
- R4: With slot 0 bit 16 set, every packet with a good sync byte is forwarded, whatever its PID and whatever the block control.
- R5: With slot 0 bit 13 set and bit 16 clear, no packet is forwarded, even when its PID matches an enabled slot.
- R6: A forwarded packet appears on out_data as exactly the bytes received, in order and with none missing. out_sop is high only on its first byte, which is 0x47. The output keeps pace with input that arrives every cycle.
- R7: A packet whose start byte is not 0x47 is dropped entirely, and sync_err_cnt goes up by one. The count saturates at its all-ones value.
- R8: Every four forwarded bytes of a packet, counted from its start byte, make one out_word. out_word_valid is high in the same cycle as the fourth byte. With slot 0 bit 14 set, the first byte sits in bits 7:0; with it clear, the first byte sits in bits 31:24.
- R9: The pass or drop decision uses the configuration in force when byte 2 is taken in. A configuration write made after that point does not affect the rest of the packet. A write made before byte 2 does.
- R10: A start byte in the middle of a packet ends that packet and begins a new one. Bytes that arrive without a start strobe after a packet has ended or been dropped produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first byte of a packet |
| in_data | input | 8 | Input stream byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_ADDR_W (6) | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is the first of a packet |
| out_data | output | 8 | Output stream byte |
| out_word_valid | output | 1 | Packed word valid |
| out_word | output | 32 | Four packed output bytes |
| sync_err_cnt | output | SYNC_CNT_W (16) | Saturating count of bad-sync packets |

## Verification
Assertions check on every cycle that each output start byte carries 0x47, and that two start bytes never follow each other. They also check that a packed word appears only together with an output byte. The sync-error count is checked to move by one step at most, and only after a bad start byte, and the output queue is checked never to overrun. Only the bench scenarios show which packets pass, because that depends on the slot contents at the moment byte 2 arrives. The same holds for how the pass-all and block controls interact, for writes that land before or after that moment, for restarts in the middle of a packet, and for the two word byte orders.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    localparam logic [7:0] TS_SYNC = 8'h47;
    localparam int PID_W = 13;

    // Register bit positions decoded by the slot bank
    localparam int BIT_PASS_ALL  = 16;
    localparam int BIT_SLOT_EN   = 15;
    localparam int BIT_LSB_FIRST = 14;
    localparam int BIT_BLOCK     = 13;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_HDR,
        PS_PASS
    } parse_state_e;

    typedef struct packed {
        logic             en;
        logic [PID_W-1:0] pid;
    } slot_cfg_t;

    typedef struct packed {
        logic pass_all;
        logic lsb_first;
        logic block;
    } glob_cfg_t;

    typedef struct packed {
        logic       sop;
        logic [7:0] data;
    } ts_byte_t;

endpackage

// File: rtl/tsf_slot_bank.sv
module tsf_slot_bank
    import tsf_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int ADDR_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [PID_W-1:0] pid_in,
    output logic             pid_hit,
    output glob_cfg_t        glob
);

    localparam int IDX_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int WIDX_W = ADDR_W - 2;

    typedef struct packed {
        slot_cfg_t [NUM_SLOTS-1:0] slot;
        glob_cfg_t                 glob;
    } bank_state_t;

    bank_state_t st_q, st_d;

    logic [WIDX_W-1:0]    widx;
    logic [IDX_W-1:0]     sidx;
    logic                 addr_ok;
    logic [NUM_SLOTS-1:0] hit_vec;
    logic                 unused_wdata;

    assign widx         = addr[ADDR_W-1:2];
    assign sidx         = widx[IDX_W-1:0];
    assign addr_ok      = (addr[1:0] == 2'b00) && (int'(widx) < NUM_SLOTS);
    assign unused_wdata = ^wdata[31:17];

    always_comb begin
        st_d = st_q;
        if (wr_en && addr_ok) begin
            st_d.slot[sidx].en  = wdata[BIT_SLOT_EN];
            st_d.slot[sidx].pid = wdata[PID_W-1:0];
            if (sidx == '0) begin
                st_d.glob.pass_all  = wdata[BIT_PASS_ALL];
                st_d.glob.lsb_first = wdata[BIT_LSB_FIRST];
                st_d.glob.block     = wdata[BIT_BLOCK];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                st_q.slot[i].en  <= 1'b0;
                st_q.slot[i].pid <= '1;
            end
            st_q.glob <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr_ok) begin
            rdata[BIT_SLOT_EN] = st_q.slot[sidx].en;
            rdata[PID_W-1:0]   = st_q.slot[sidx].pid;
            if (sidx == '0) begin
                rdata[BIT_PASS_ALL]  = st_q.glob.pass_all;
                rdata[BIT_LSB_FIRST] = st_q.glob.lsb_first;
                rdata[BIT_BLOCK]     = st_q.glob.block;
            end
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = st_q.slot[g].en && (st_q.slot[g].pid == pid_in);
    end

    assign pid_hit = |hit_vec;
    assign glob    = st_q.glob;

endmodule

// File: rtl/tsf_out_fifo.sv
module tsf_out_fifo
    import tsf_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       push_cnt,
    input  ts_byte_t [2:0]   push_ent,
    output logic             pop_vld,
    output ts_byte_t         pop_ent,
    output logic             out_vld,
    output ts_byte_t         out_ent,
    output logic [LVL_W-1:0] level
);

    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        ts_byte_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]     wr;
        logic [PTR_W-1:0]     rd;
        logic [LVL_W-1:0]     lvl;
        logic                 ovld;
        ts_byte_t             oent;
    } fifo_state_t;

    fifo_state_t q, d;

    always_comb begin
        d       = q;
        pop_vld = (q.lvl != '0);
        pop_ent = q.mem[q.rd];
        for (int i = 0; i < 3; i++) begin
            if (i < int'(push_cnt)) begin
                d.mem[q.wr + PTR_W'(i)] = push_ent[i];
            end
        end
        d.wr   = q.wr + PTR_W'(push_cnt);
        d.rd   = q.rd + PTR_W'(pop_vld);
        d.lvl  = q.lvl + LVL_W'(push_cnt) - LVL_W'(pop_vld);
        d.ovld = pop_vld;
        d.oent = pop_vld ? pop_ent : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_vld = q.ovld;
    assign out_ent = q.oent;
    assign level   = q.lvl;

endmodule

// File: rtl/tsf_word_packer.sv
module tsf_word_packer
    import tsf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  ts_byte_t    in_ent,
    input  logic        lsb_first,
    output logic        word_vld,
    output logic [31:0] word
);

    typedef struct packed {
        logic [1:0]  idx;
        logic [31:0] acc;
        logic        wv;
        logic [31:0] word;
    } pack_state_t;

    pack_state_t q, d;

    logic [1:0]  eff;
    logic [1:0]  lane;
    logic [31:0] tmp;

    always_comb begin
        d    = q;
        d.wv = 1'b0;
        eff  = in_ent.sop ? 2'd0 : q.idx;
        lane = lsb_first ? eff : (2'd3 - eff);
        tmp  = in_ent.sop ? '0 : q.acc;
        tmp[{lane, 3'b000} +: 8] = in_ent.data;
        if (in_vld) begin
            d.acc = tmp;
            d.idx = eff + 2'd1;
            if (eff == 2'd3) begin
                d.wv   = 1'b1;
                d.word = tmp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign word_vld = q.wv;
    assign word     = q.word;

endmodule

// File: rtl/tsf_pid_filter.sv
module tsf_pid_filter
    import tsf_pkg::*;
#(
    parameter  int NUM_SLOTS  = 8,
    parameter  int PKT_LEN    = 188,
    parameter  int FIFO_DEPTH = 4,
    parameter  int SYNC_CNT_W = 16,
    localparam int CFG_ADDR_W = $clog2(NUM_SLOTS) + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic [7:0]            in_data,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    output logic                  out_valid,
    output logic                  out_sop,
    output logic [7:0]            out_data,
    output logic                  out_word_valid,
    output logic [31:0]           out_word,
    output logic [SYNC_CNT_W-1:0] sync_err_cnt
);

    localparam int CNT_W = $clog2(PKT_LEN);
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        parse_state_e          st;
        logic [CNT_W-1:0]      cnt;
        logic [7:0]            hold0;
        logic [7:0]            hold1;
        logic [SYNC_CNT_W-1:0] sync_cnt;
    } parse_t;

    parse_t q, d;

    logic [PID_W-1:0] pid_now;
    logic             pid_hit;
    glob_cfg_t        glob;
    logic             accept;
    logic [1:0]       push_cnt;
    ts_byte_t [2:0]   push_ent;
    logic             pop_vld;
    ts_byte_t         pop_ent;
    logic             fifo_out_vld;
    ts_byte_t         fifo_out_ent;
    logic [LVL_W-1:0] fifo_level;

    assign pid_now = {q.hold1[4:0], in_data};
    assign accept  = glob.pass_all || (!glob.block && pid_hit);

    tsf_slot_bank #(
        .NUM_SLOTS(NUM_SLOTS),
        .ADDR_W   (CFG_ADDR_W)
    ) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .pid_in (pid_now),
        .pid_hit(pid_hit),
        .glob   (glob)
    );

    always_comb begin
        d        = q;
        push_cnt = 2'd0;
        push_ent = '0;
        if (in_valid) begin
            if (in_sop) begin
                d.cnt = CNT_W'(1);
                if (in_data == TS_SYNC) begin
                    d.st    = PS_HDR;
                    d.hold0 = in_data;
                end else begin
                    d.st = PS_IDLE;
                    if (q.sync_cnt != '1) begin
                        d.sync_cnt = q.sync_cnt + 1'b1;
                    end
                end
            end else begin
                unique case (q.st)
                    PS_HDR: begin
                        if (q.cnt == CNT_W'(1)) begin
                            d.hold1 = in_data;
                            d.cnt   = CNT_W'(2);
                        end else begin
                            d.cnt = CNT_W'(3);
                            if (accept) begin
                                push_cnt         = 2'd3;
                                push_ent[0].sop  = 1'b1;
                                push_ent[0].data = q.hold0;
                                push_ent[1].data = q.hold1;
                                push_ent[2].data = in_data;
                                d.st             = PS_PASS;
                            end else begin
                                d.st = PS_IDLE;
                            end
                        end
                    end
                    PS_PASS: begin
                        push_cnt         = 2'd1;
                        push_ent[0].data = in_data;
                        d.cnt            = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(PKT_LEN - 1)) begin
                            d.st = PS_IDLE;
                        end
                    end
                    default: begin
                        d.st = PS_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: PS_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    tsf_out_fifo #(
        .DEPTH(FIFO_DEPTH)
    ) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_cnt(push_cnt),
        .push_ent(push_ent),
        .pop_vld (pop_vld),
        .pop_ent (pop_ent),
        .out_vld (fifo_out_vld),
        .out_ent (fifo_out_ent),
        .level   (fifo_level)
    );

    tsf_word_packer packer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (pop_vld),
        .in_ent   (pop_ent),
        .lsb_first(glob.lsb_first),
        .word_vld (out_word_valid),
        .word     (out_word)
    );

    assign out_valid    = fifo_out_vld;
    assign out_sop      = fifo_out_ent.sop;
    assign out_data     = fifo_out_ent.data;
    assign sync_err_cnt = q.sync_cnt;

endmodule

// File: rtl/tsf_pid_filter_chk.sv
module tsf_pid_filter_chk #(
    parameter int SYNC_CNT_W = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int LVL_W      = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_sop,
    input logic [7:0]            in_data,
    input logic                  out_valid,
    input logic                  out_sop,
    input logic [7:0]            out_data,
    input logic                  out_word_valid,
    input logic [SYNC_CNT_W-1:0] sync_err_cnt,
    input logic [LVL_W-1:0]      fifo_level,
    input logic [1:0]            push_cnt
);

    assert_sop_is_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> (out_data == 8'h47))
        else $error("output start byte is not 0x47");

    assert_no_back_to_back_sop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |=> !(out_valid && out_sop))
        else $error("two output start bytes in a row");

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(fifo_level) + 32'(push_cnt)) <= FIFO_DEPTH)
        else $error("output queue would overrun");

    assert_word_with_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_word_valid |-> out_valid)
        else $error("packed word without an output byte");

    assert_sync_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err_cnt == $past(sync_err_cnt)) || (sync_err_cnt == $past(sync_err_cnt) + 1'b1))
        else $error("sync error count jumped");

    assert_sync_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err_cnt != $past(sync_err_cnt)) |-> $past(in_valid && in_sop && (in_data != 8'h47)))
        else $error("sync error count moved without a bad start byte");

endmodule

bind tsf_pid_filter tsf_pid_filter_chk #(
    .SYNC_CNT_W(SYNC_CNT_W),
    .FIFO_DEPTH(FIFO_DEPTH),
    .LVL_W     (LVL_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_sop        (in_sop),
    .in_data       (in_data),
    .out_valid     (out_valid),
    .out_sop       (out_sop),
    .out_data      (out_data),
    .out_word_valid(out_word_valid),
    .sync_err_cnt  (sync_err_cnt),
    .fifo_level    (fifo_level),
    .push_cnt      (push_cnt)
);

// File: tb/tsf_pid_filter_tb_top.sv
module tsf_pid_filter_tb_top;

    localparam int SCW = 3;
    localparam int SYNC_MAX = (1 << SCW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_sop = 1'b0;
    logic [7:0]     in_data = '0;
    logic           cfg_we = 1'b0;
    logic [5:0]     cfg_addr = '0;
    logic [31:0]    cfg_wdata = '0;
    logic [31:0]    cfg_rdata;
    logic           out_valid;
    logic           out_sop;
    logic [7:0]     out_data;
    logic           out_word_valid;
    logic [31:0]    out_word;
    logic [SCW-1:0] sync_err_cnt;

    always #4 clk = ~clk;

    tsf_pid_filter #(.SYNC_CNT_W(SCW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
        .out_word_valid(out_word_valid), .out_word(out_word), .sync_err_cnt(sync_err_cnt)
    );

    int          n_checks = 0;
    int          n_errs = 0;
    logic [31:0] slot_m [8];
    int          sync_m = 0;
    logic [8:0]  got_b [$];
    logic [8:0]  exp_b [$];
    logic [31:0] got_w [$];

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) got_b.push_back({out_sop, out_data});
            if (out_word_valid) got_w.push_back(out_word);
        end
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] masked(int idx, logic [31:0] v);
        return (idx == 0) ? (v & 32'h0001_FFFF) : (v & 32'h0000_9FFF);
    endfunction

    function automatic bit m_accept(logic [12:0] pid);
        bit hit = 1'b0;
        for (int i = 0; i < 8; i++)
            if (slot_m[i][15] && slot_m[i][12:0] == pid) hit = 1'b1;
        return slot_m[0][16] || (!slot_m[0][13] && hit);
    endfunction

    task automatic cfg_write(int addr, logic [31:0] v);
        @(negedge clk);
        in_valid  = 1'b0;
        in_sop    = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = addr[5:0];
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr[1:0] == 2'b00 && addr < 32) slot_m[addr >> 2] = masked(addr >> 2, v);
    endtask

    task automatic cfg_check(int addr, string req);
        logic [31:0] e;
        @(negedge clk);
        cfg_addr = addr[5:0];
        #1;
        e = (addr[1:0] == 2'b00 && addr < 32) ? slot_m[addr >> 2] : 32'h0;
        check(cfg_rdata == e, req, "register readback", cfg_rdata, e);
    endtask

    task automatic put_byte(logic [7:0] b, bit sop);
        @(negedge clk);
        cfg_we   = 1'b0;
        in_valid = 1'b1;
        in_sop   = sop;
        in_data  = b;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sop   = 1'b0;
        end
    endtask

    // chg: 0 none, 1 park kill_idx after byte 1, 2 park kill_idx after byte 2
    task automatic send_pkt(logic [12:0] pid, bit good, int gap_pct, int chg, int kill_idx, int len);
        logic [7:0] b;
        bit dec = 1'b0;
        logic [8:0] pend [$];
        for (int i = 0; i < len; i++) begin
            if (i == 0) b = good ? 8'h47 : 8'hB8;
            else if (i == 1) b = {3'($urandom % 8), pid[12:8]};
            else if (i == 2) b = pid[7:0];
            else b = 8'($urandom);
            put_byte(b, i == 0);
            pend.push_back({(i == 0), b});
            if (i == 2) dec = good && m_accept(pid);
            if ((i == 1 && chg == 1) || (i == 2 && chg == 2))
                cfg_write(4 * kill_idx, (kill_idx == 0) ? ((slot_m[0] & 32'h0001_6000) | 32'h1FFF) : 32'h1FFF);
            if (($urandom % 100) < gap_pct) idle(1);
        end
        if (!good) sync_m = (sync_m < SYNC_MAX) ? sync_m + 1 : SYNC_MAX;
        if (dec) foreach (pend[k]) exp_b.push_back(pend[k]);
    endtask

    task automatic compare_stream(string req);
        logic [31:0] ew [$];
        logic [31:0] w = '0;
        int idx = 0;
        int lane;
        int bad = -1;
        idle(8);
        check(got_b.size() == exp_b.size(), req, "byte count", got_b.size(), exp_b.size());
        for (int i = 0; i < exp_b.size() && i < got_b.size(); i++)
            if (bad < 0 && got_b[i] != exp_b[i]) bad = i;
        if (bad >= 0) check(1'b0, req, "byte content", 32'(got_b[bad]), 32'(exp_b[bad]));
        else check(1'b1, req, "byte content", 0, 0);
        foreach (exp_b[i]) begin
            if (exp_b[i][8]) idx = 0;
            lane = slot_m[0][14] ? idx : 3 - idx;
            w[lane*8 +: 8] = exp_b[i][7:0];
            if (idx == 3) ew.push_back(w);
            idx = (idx + 1) % 4;
        end
        check(got_w.size() == ew.size(), "R8", "word count", got_w.size(), ew.size());
        bad = -1;
        for (int i = 0; i < ew.size() && i < got_w.size(); i++)
            if (bad < 0 && got_w[i] != ew[i]) bad = i;
        if (bad >= 0) check(1'b0, "R8", "word content", got_w[bad], ew[bad]);
        else check(1'b1, "R8", "word content", 0, 0);
        check(32'(sync_err_cnt) == sync_m, "R7", "sync error count", 32'(sync_err_cnt), sync_m);
        got_b.delete();
        got_w.delete();
        exp_b.delete();
    endtask

    function automatic logic [12:0] pick_pid();
        case ($urandom % 5)
            0: return 13'h0100;
            1: return 13'h0101;
            2: return 13'h0000;
            3: return 13'h1FFF;
            default: return 13'h0ABC;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL R6 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) slot_m[i] = 32'h1FFF;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R2: reset state
        check(out_valid == 1'b0 && out_word_valid == 1'b0, "R2", "outputs after reset",
              {out_valid, out_word_valid}, 0);
        check(sync_err_cnt == '0, "R2", "sync count after reset", 32'(sync_err_cnt), 0);
        for (int i = 0; i < 8; i++) cfg_check(4 * i, "R2");

        // R1: field storage and unmapped addresses
        cfg_write(12, 32'hFFFF_FFFF);
        cfg_check(12, "R1");
        cfg_write(0, 32'hFFFF_FFFF);
        cfg_check(0, "R1");
        cfg_write(0, 32'h0000_1FFF);
        cfg_write(13, 32'h0000_0000);
        cfg_check(12, "R1");
        cfg_check(13, "R1");
        cfg_write(36, 32'h0000_8123);
        cfg_check(36, "R1");
        cfg_write(12, 32'h0000_1FFF);
        cfg_check(12, "R1");

        // R3: matching on an enabled slot only
        cfg_write(8, 32'h0000_8100);
        send_pkt(13'h0100, 1'b1, 0, 0, 0, 188);
        compare_stream("R3 enabled match");
        send_pkt(13'h0101, 1'b1, 20, 0, 0, 188);
        compare_stream("R3 no match");
        cfg_write(20, 32'h0000_0101);
        send_pkt(13'h0101, 1'b1, 0, 0, 0, 188);
        compare_stream("R3 disabled slot");
        cfg_write(28, 32'h0000_8000);
        send_pkt(13'h0000, 1'b1, 0, 0, 0, 188);
        send_pkt(13'h0100, 1'b1, 0, 0, 0, 188);
        compare_stream("R6 back-to-back packets");

        // R5: block control
        cfg_write(0, 32'h0000_3FFF);
        send_pkt(13'h0100, 1'b1, 0, 0, 0, 188);
        compare_stream("R5 block");
        // R4: pass-all overrides block
        cfg_write(0, 32'h0001_3FFF);
        send_pkt(13'h1ABC, 1'b1, 10, 0, 0, 188);
        compare_stream("R4 pass-all with block");
        // R8: other byte order with pass-all
        cfg_write(0, 32'h0001_5FFF);
        send_pkt(13'h0ABC, 1'b1, 0, 0, 0, 188);
        compare_stream("R8 low-lane-first");
        cfg_write(0, 32'h0000_1FFF);

        // R9: decision latch point
        send_pkt(13'h0100, 1'b1, 0, 2, 2, 188);
        compare_stream("R9 write after byte 2");
        cfg_write(8, 32'h0000_8100);
        send_pkt(13'h0100, 1'b1, 0, 1, 2, 188);
        compare_stream("R9 write before byte 2");
        cfg_write(8, 32'h0000_8100);

        // R10: restart mid-packet, stray bytes ignored
        send_pkt(13'h0100, 1'b1, 0, 0, 0, 10);
        send_pkt(13'h0100, 1'b1, 0, 0, 0, 188);
        for (int i = 0; i < 5; i++) put_byte(8'(i), 1'b0);
        compare_stream("R10 restart and stray bytes");
        send_pkt(13'h0555, 1'b1, 0, 0, 0, 188);
        for (int i = 0; i < 4; i++) put_byte(8'h47, 1'b0);
        compare_stream("R10 bytes after dropped packet");

        // R7: bad sync dropped even with pass-all, count saturates
        cfg_write(0, 32'h0001_1FFF);
        for (int i = 0; i < SYNC_MAX + 2; i++) send_pkt(13'h0100, 1'b0, 0, 0, 0, 12);
        compare_stream("R7 bad sync saturation");
        cfg_write(0, 32'h0000_1FFF);

        // Random mix
        for (int it = 0; it < 40; it++) begin
            if ($urandom % 2) begin
                int k = $urandom % 8;
                logic [31:0] v = {16'h0, 1'($urandom % 2), 2'b00, pick_pid()};
                if (k == 0) begin
                    v[16] = (($urandom % 4) == 0);
                    v[13] = (($urandom % 4) == 0);
                    v[14] = 1'($urandom % 2);
                end
                cfg_write(4 * k, v);
            end
            send_pkt(pick_pid(), ($urandom % 8) != 0, ($urandom % 2) ? 30 : 0, 0, 0, 188);
            compare_stream("R3 random mix");
        end

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule